// File: doc/BRIEF.md
# Transfer Length Splitter

This block turns one data transfer request into the ordered list of 32-bit command words that a serial flash sequencer consumes. A request carries a byte count, a direction (transmit or receive) and a lane width. The sequencer's command word holds only an 8-bit count field. Large lengths are therefore cut into power-of-two pieces, each written as a bit exponent, and any tail of fewer than 256 bytes goes into one plain byte-count word.

The power-of-two pieces are peeled off from the low end. Each exponent word removes the smallest power of two of at least 256 that is still set in the remaining count, so the exponents rise from one word to the next. When the remainder drops to 255 or below, one count word carries it and the request finishes. A one-cycle done pulse follows the acceptance of the final word. A zero-length request produces only the done pulse.

Top module: `chunk_cmd_gen`

## Requirements
- R1: After reset, `req_ready` is 1 and `cmd_valid` and `done` are 0.
- R2: While the remaining count exceeds 255, each word has bit 9 set. Bits [7:0] hold the index of the lowest set bit of the remaining count at index 8 or above, and that power of two is subtracted once the word is accepted.
- R3: When the remaining count is 1 to 255, one word is emitted with bit 9 clear and bits [7:0] equal to that count. That word is the last one for the request.
- R4: When the remaining count reaches exactly zero after an exponent word (the length is a multiple of 256 at that point), no count word follows.
- R5: A request of length 0 emits no word. `done` is 1 in the cycle after the request is accepted.
- R6: Every word has bit 8 set. Bit 16 is set and bit 17 clear for transmit (`req_dir`=0), and the reverse for receive (`req_dir`=1).
- R7: Bits [11:10] encode the lane width: 1 lane gives 01, 2 lanes give 10, 4 lanes give 11. Any other `req_lanes` value gives 01.
- R8: Bits 12 and 14 are set in every word. Bits 13, 15 and 18 to 31 are clear.
- R9: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_data` and `cmd_valid` stay unchanged in the next cycle.
- R10: `req_ready` is 1 only when no request is in progress. `done` pulses for one cycle in the cycle after the last word is accepted, and a new request may be accepted in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_len | input | LEN_W | Byte count of the transfer |
| req_dir | input | 1 | 0 = transmit, 1 = receive |
| req_lanes | input | 3 | Lane width: 1, 2 or 4 |
| cmd_valid | output | 1 | Command word offered |
| cmd_ready | input | 1 | Sequencer takes the word |
| cmd_data | output | 32 | Command word |
| done | output | 1 | One-cycle pulse when a request is finished |

## Verification
Two events can land in the same cycle. One is the done pulse that closes a request. The other is the acceptance of the next request, including a zero-length request whose own done pulse follows one cycle later. The bench provokes this overlap by offering each new request as soon as `req_ready` rises, so some new requests are taken in the very cycle that `done` is high. It then judges two things: that the next request's word stream lines up exactly with its predicted queue, and that every done pulse sits one cycle after its final word or after its zero-length acceptance. Random stalls on `cmd_ready` also delay final words while the next request is waiting.

// File: rtl/chunk_pkg.sv
package chunk_pkg;
   localparam int unsigned CMD_W    = 32;
   localparam int unsigned FIELD_W  = 8;
   localparam int unsigned POS_XFER = 8;
   localparam int unsigned POS_EXP  = 9;
   localparam int unsigned POS_MODE = 10;
   localparam int unsigned POS_CS   = 12;
   localparam int unsigned POS_BUS  = 14;
   localparam int unsigned POS_TX   = 16;
   localparam int unsigned POS_RX   = 17;

   typedef enum logic [1:0] {
      LANE_NONE = 2'd0,
      LANE_X1   = 2'd1,
      LANE_X2   = 2'd2,
      LANE_X4   = 2'd3
   } lane_mode_e;

   typedef struct packed {
      logic       rx;
      lane_mode_e mode;
   } xfer_attr_t;

   function automatic lane_mode_e lanes_to_mode(input logic [2:0] lanes);
      case (lanes)
         3'd2:    return LANE_X2;
         3'd4:    return LANE_X4;
         default: return LANE_X1;
      endcase
   endfunction
endpackage

// File: rtl/chunk_pick.sv
module chunk_pick
   import chunk_pkg::*;
#(
   parameter int unsigned LEN_W = 32
) (
   input  logic [LEN_W-1:0]   rem,
   output logic               is_exp,
   output logic [FIELD_W-1:0] field,
   output logic [LEN_W-1:0]   take
);
   localparam int unsigned LOW_W = FIELD_W;
   localparam int unsigned HI_W  = LEN_W - LOW_W;

   logic [LEN_W-1:0] hi_part;
   logic [LEN_W-1:0] low_hot;
   logic [FIELD_W-1:0] idx_bits [LEN_W+1];

   assign hi_part = {rem[LEN_W-1:LOW_W], {LOW_W{1'b0}}};
   assign is_exp  = |rem[LEN_W-1:LOW_W];
   assign low_hot = hi_part & (~hi_part + 1'b1);

   assign idx_bits[LOW_W] = '0;
   generate
      for (genvar i = 0; i < LOW_W; i++) begin : g_pad
         assign idx_bits[i] = '0;
      end
      for (genvar i = LOW_W; i < LEN_W; i++) begin : g_enc
         assign idx_bits[i+1] = idx_bits[i] | (low_hot[i] ? FIELD_W'(i) : '0);
      end
   endgenerate

   assign field = is_exp ? idx_bits[LEN_W] : rem[FIELD_W-1:0];
   assign take  = is_exp ? low_hot : rem;

   initial begin
      if (HI_W < 1) $error("chunk_pick: LEN_W must exceed FIELD_W");
   end
endmodule

// File: rtl/chunk_fmt.sv
module chunk_fmt
   import chunk_pkg::*;
(
   input  xfer_attr_t         attr,
   input  logic               is_exp,
   input  logic [FIELD_W-1:0] field,
   output logic [CMD_W-1:0]   word
);
   always_comb begin
      word                  = '0;
      word[FIELD_W-1:0]     = field;
      word[POS_XFER]        = 1'b1;
      word[POS_EXP]         = is_exp;
      word[POS_MODE +: 2]   = attr.mode;
      word[POS_CS]          = 1'b1;
      word[POS_BUS]         = 1'b1;
      word[POS_TX]          = ~attr.rx;
      word[POS_RX]          = attr.rx;
   end
endmodule

// File: rtl/chunk_cmd_gen.sv
module chunk_cmd_gen
   import chunk_pkg::*;
#(
   parameter int unsigned LEN_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [LEN_W-1:0] req_len,
   input  logic             req_dir,
   input  logic [2:0]       req_lanes,
   output logic             cmd_valid,
   input  logic             cmd_ready,
   output logic [CMD_W-1:0] cmd_data,
   output logic             done
);
   generate
      if (LEN_W < FIELD_W + 1 || LEN_W > 64) begin : g_bad_len
         $error("chunk_cmd_gen: LEN_W out of range");
      end
   endgenerate

   logic               busy;
   logic [LEN_W-1:0]   rem_q;
   xfer_attr_t         attr_q;
   logic               done_q;
   logic               pick_exp;
   logic [FIELD_W-1:0] pick_field;
   logic [LEN_W-1:0]   pick_take;
   logic               req_fire;
   logic               cmd_fire;

   chunk_pick #(.LEN_W(LEN_W)) u_pick (
      .rem    (rem_q),
      .is_exp (pick_exp),
      .field  (pick_field),
      .take   (pick_take)
   );

   chunk_fmt u_fmt (
      .attr   (attr_q),
      .is_exp (pick_exp),
      .field  (pick_field),
      .word   (cmd_data)
   );

   assign req_ready = ~busy;
   assign cmd_valid = busy;
   assign done      = done_q;
   assign req_fire  = req_valid & req_ready;
   assign cmd_fire  = cmd_valid & cmd_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         rem_q  <= '0;
         attr_q <= '{rx: 1'b0, mode: LANE_X1};
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (req_fire) begin
            rem_q       <= req_len;
            attr_q.rx   <= req_dir;
            attr_q.mode <= lanes_to_mode(req_lanes);
            if (req_len == '0) done_q <= 1'b1;
            else               busy   <= 1'b1;
         end else if (cmd_fire) begin
            rem_q <= rem_q - pick_take;
            if (rem_q == pick_take) begin
               busy   <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   // R9: a stalled word is held unchanged
   p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data));
   // R6: data-transfer bit always present
   p_xfer_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> cmd_data[POS_XFER]);
   // R6: exactly one of transmit/receive
   p_one_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> $countones(cmd_data[POS_RX:POS_TX]) == 1);
   // R2: exponent words never name a bit below 8
   p_exp_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_data[POS_EXP] |-> cmd_data[FIELD_W-1:0] >= FIELD_W);
   // R3: a count word never carries zero
   p_imm_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_data[POS_EXP] |-> cmd_data[FIELD_W-1:0] != '0);
   // R8: fixed select bits set, spare bits clear
   p_fixed_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> cmd_data[POS_CS] && cmd_data[POS_BUS] && !cmd_data[13]
                    && !cmd_data[15] && cmd_data[CMD_W-1:18] == '0);
   // R10: done pulse is a single cycle and comes with no word pending
   p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !cmd_valid);
   p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done && !req_valid |=> !done);
endmodule

// File: tb/chunk_cmd_gen_bench.sv
`timescale 1ns/1ps
module chunk_cmd_gen_bench;
   localparam int unsigned LEN_W = 32;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic             req_ready;
   logic [LEN_W-1:0] req_len = '0;
   logic             req_dir = 1'b0;
   logic [2:0]       req_lanes = 3'd1;
   logic             cmd_valid;
   logic             cmd_ready = 1'b0;
   logic [31:0]      cmd_data;
   logic             done;

   always #2 clk = ~clk;

   chunk_cmd_gen #(.LEN_W(LEN_W)) u_chunk_cmd_gen (
      .clk, .rst_n, .req_valid, .req_ready, .req_len, .req_dir, .req_lanes,
      .cmd_valid, .cmd_ready, .cmd_data, .done
   );

   int          n_vec = 0;
   int          n_bad = 0;
   logic [31:0] exp_q[$];
   bit          last_q[$];
   bit          zero_pending = 0;
   bit          mon_on = 0;
   bit          stall_mode = 0;
   bit          all_sent = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] expv);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   function automatic logic [31:0] base_word(input bit dir, input logic [2:0] lanes);
      logic [31:0] w = 32'h0000_5100;   // bits 14, 12, 8
      logic [1:0]  m;
      w |= dir ? 32'h0002_0000 : 32'h0001_0000;
      m = (lanes == 3'd2) ? 2'b10 : (lanes == 3'd4) ? 2'b11 : 2'b01;
      w[11:10] = m;
      return w;
   endfunction

   // driver: predicts the words from the requirements and offers the request
   task automatic send(input logic [LEN_W-1:0] len, input bit dir, input logic [2:0] lanes);
      logic [LEN_W-1:0] r = len;
      logic [31:0] b = base_word(dir, lanes);
      int e;
      while (r > 255) begin
         e = 8;
         while (!r[e]) e++;
         r = r - (LEN_W'(1) << e);
         exp_q.push_back(b | 32'h200 | 32'(e));
         last_q.push_back(r == 0);
      end
      if (r != 0) begin
         exp_q.push_back(b | 32'(r[7:0]));
         last_q.push_back(1'b1);
      end
      @(negedge clk); #1;
      while (!req_ready) begin @(negedge clk); #1; end
      req_valid = 1'b1; req_len = len; req_dir = dir; req_lanes = lanes;
      if (len == 0) zero_pending = 1'b1;
      @(negedge clk); #1;
      req_valid = 1'b0;
   endtask

   // monitor / scoreboard
   initial begin
      logic [15:0] lfsr = 16'hACE1;
      bit last_pend = 0, hold_pend = 0, exp_done, lst;
      logic [31:0] hold_word, e, a;
      wait (mon_on);
      forever begin
         @(negedge clk);
         exp_done = last_pend | zero_pending;
         chk(done == exp_done, zero_pending ? "R5 done" : "R10 done", 32'(done), 32'(exp_done));
         zero_pending = 0; last_pend = 0;
         if (done) chk(req_ready, "R10 ready with done", 32'(req_ready), 32'd1);
         if (hold_pend) begin
            chk(cmd_valid && cmd_data == hold_word, "R9 hold", cmd_data, hold_word);
            hold_pend = 0;
         end
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         cmd_ready = stall_mode ? (lfsr[0] & lfsr[3]) : (lfsr[0] | lfsr[5]);
         if (cmd_valid && cmd_ready) begin
            a = cmd_data;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R4 unexpected word", a, 32'h0);
            end else begin
               e = exp_q.pop_front();
               lst = last_q.pop_front();
               chk({a[9], a[7:0]} == {e[9], e[7:0]}, e[9] ? "R2 exponent" : "R3 count", a, e);
               chk(a[8] == e[8] && a[17:16] == e[17:16], "R6 dir", a, e);
               chk(a[11:10] == e[11:10], "R7 mode", a, e);
               chk({a[31:18], a[15:12]} == {e[31:18], e[15:12]}, "R8 fixed", a, e);
               last_pend = lst;
            end
         end else if (cmd_valid) begin
            hold_pend = 1; hold_word = cmd_data;
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1 && cmd_valid == 1'b0 && done == 1'b0, "R1 reset",
          {29'd0, req_ready, cmd_valid, done}, 32'h4);
      #1 rst_n = 1'b1;
      mon_on = 1'b1;
      send(0, 0, 3'd1);            // R5
      send(5, 0, 3'd1);            // R3, R6 transmit
      send(255, 1, 3'd2);          // R3 upper edge, R7 dual
      send(256, 0, 3'd4);          // R4, R7 quad
      send(0, 1, 3'd4);            // R5 right after done, R10
      send(32'h1305, 1, 3'd3);     // R2 rising exponents, R7 fallback
      send(768, 0, 3'd0);          // R4 two exponents, R7 fallback
      stall_mode = 1'b1;
      send(32'h1FF, 1, 3'd1);      // R2 + R3 under stalls, R9
      send(32'hFFFF, 0, 3'd2);     // R2 many exponents
      send(32'h10000, 1, 3'd4);    // R4 single exponent
      stall_mode = 1'b0;
      send(32'h8000_0001, 0, 3'd1); // R2 top exponent
      send(1, 1, 3'd4);            // R3 minimum
      send(0, 0, 3'd2);            // R5
      all_sent = 1'b1;
      while (exp_q.size() != 0 || cmd_valid) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R4 leftover", 32'(exp_q.size()), 32'd0);
      chk(!cmd_valid && req_ready, "R10 idle at end", 32'(cmd_valid), 32'd0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule